// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and takes the memory from power-up to a usable state. After reset it holds clock enable high and fills the command bus with NO OPERATION for a stabilization period. The period is computed from the clock frequency in MHz and a wait time in microseconds. It then closes every bank with a precharge, runs two auto refresh cycles, and programs the mode register from a configuration word. Every command is followed by a parameterised gap, in clock cycles, that is filled with NO OPERATION.

Once the last gap has elapsed the block raises a completion flag. The flag stays high until the next reset. A memory controller waits on this flag before it issues any read, write or refresh traffic. All command, address, bank and flag outputs come from flops. The command bus therefore trails the internal sequence by one cycle.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted the pins show NO OPERATION ({cs_n,ras_n,cas_n,we_n} = 0111), clock enable is 1, the address is 0 and the done flag is 0.
- R2: Clock enable is 1 in every cycle.
- R3: After reset is released, exactly STAB = CLK_MHZ*WAIT_US cycles of NO OPERATION (never a deselect) are shown before the first non-NOP command. Counting the first cycle after release as cycle 1, the precharge appears in cycle STAB+1.
- R4: The first command is a precharge of all banks, coded 0010, with address bit 10 set to 1.
- R5: The first AUTO REFRESH (code 0001) appears exactly T_RP cycles after the precharge, with only NO OPERATION between them.
- R6: Exactly two AUTO REFRESH commands are issued, T_RC cycles apart. The mode load follows the second refresh by T_RC cycles. No other command is issued during the sequence.
- R7: The mode load is coded 0000 and the bank lines are 0. Address bits [6:0] and [9] equal the same bits of the configuration word. Bits [8:7], [11:10] and every bit above them are 0.
- R8: The done flag rises exactly T_MRD cycles after the mode load cycle, with NO OPERATION in between. It then stays high and the bus stays at NO OPERATION until reset.
- R9: A reset asserted part-way through the sequence restarts it from the beginning, including the full stabilization wait.
- R10: After done, changes on the configuration input have no effect: the address stays 0 and the command stays NO OPERATION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | ADDR_W | Mode register configuration word |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines |
| sd_ba | output | BA_W | Bank select lines |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench measures the exact cycle of every command relative to reset release. An off-by-one in a counter load or in the stabilization compare therefore moves the precharge, a refresh or the done flag by one cycle, and that shift is reported. Configuration words with the reserved and operating-mode bits set show whether the design masks them; a design that copies the word straight through would put ones in bits [11:10] or [8:7]. A reset issued just after the precharge shows whether the refresh counter and timer are cleared. A design that resumed mid-sequence, or kept a stale refresh count, would show the precharge early or only one refresh. Random configuration changes after completion reveal an address path that was left transparent.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    K_NOP,
    K_PRE,
    K_REF,
    K_MRS
  } cmd_kind_t;

  typedef enum logic [2:0] {
    ST_STAB,
    ST_PRE,
    ST_PGAP,
    ST_REF,
    ST_RGAP,
    ST_MRS,
    ST_MGAP,
    ST_DONE
  } seq_state_t;

  localparam int NUM_REF = 2;
  localparam int ALL_BANK_BIT = 10;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_kind_t k);
    case (k)
      K_PRE:   return 4'b0010;
      K_REF:   return 4'b0001;
      K_MRS:   return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic int unsigned stab_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= RST_VAL;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5: a reload takes effect on the following cycle
  assert_timer_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/init_fsm.sv
module init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_RP  = 3,
  parameter int T_RC  = 8,
  parameter int T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output cmd_kind_t        kind,
  output logic             seq_done
);
  localparam int RC_W = $clog2(NUM_REF + 1);
  localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] GAP_RC  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 2);

  seq_state_t st, nxt;
  logic [RC_W-1:0] ref_cnt;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_STAB: if (tmr_zero) nxt = ST_PRE;
      ST_PRE:  begin nxt = ST_PGAP; tmr_load = 1'b1; tmr_val = GAP_RP; end
      ST_PGAP: if (tmr_zero) nxt = ST_REF;
      ST_REF:  begin nxt = ST_RGAP; tmr_load = 1'b1; tmr_val = GAP_RC; end
      ST_RGAP: if (tmr_zero) nxt = (ref_cnt == RC_W'(NUM_REF)) ? ST_MRS : ST_REF;
      ST_MRS:  begin nxt = ST_MGAP; tmr_load = 1'b1; tmr_val = GAP_MRD; end
      ST_MGAP: if (tmr_zero) nxt = ST_DONE;
      default: nxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_STAB;
      ref_cnt <= '0;
    end else begin
      st <= nxt;
      if (st == ST_REF) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  always_comb begin
    case (st)
      ST_PRE:  kind = K_PRE;
      ST_REF:  kind = K_REF;
      ST_MRS:  kind = K_MRS;
      default: kind = K_NOP;
    endcase
  end

  assign seq_done = (st == ST_DONE);

  // R6: mode load is reached only after both refreshes
  assert_two_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MRS) |-> (ref_cnt == RC_W'(NUM_REF)));

  // R6: no refresh beyond the second
  assert_refresh_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REF) |-> (ref_cnt < RC_W'(NUM_REF)));

endmodule

// File: rtl/init_cmd_drv.sv
module init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_t         kind,
  input  logic              done_in,
  input  logic [ADDR_W-1:0] cfg,
  output logic [3:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BA_W-1:0]   ba_q,
  output logic              cke_q,
  output logic              done_q
);
  function automatic logic [ADDR_W-1:0] keep_mask();
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 0; i < 7; i++) m[i] = 1'b1;
    m[9] = 1'b1;
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] KEEP    = keep_mask();
  localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << ALL_BANK_BIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= cmd_pins(K_NOP);
      addr_q <= '0;
      ba_q   <= '0;
      cke_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_pins(kind);
      ba_q   <= '0;
      cke_q  <= 1'b1;
      done_q <= done_in;
      case (kind)
        K_PRE:   addr_q <= PRE_ALL;
        K_MRS:   addr_q <= cfg & KEEP;
        default: addr_q <= '0;
      endcase
    end
  end

  // R4: precharge always carries the all-banks select
  assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 4'b0010) |-> addr_q[ALL_BANK_BIT]);

  // R7: reserved and operating-mode fields cleared on the mode load
  assert_mode_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 4'b0000) |-> (addr_q[8:7] == 2'b00 && addr_q[11:10] == 2'b00));

  // R8: done is sticky
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R8: bus idle once done
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cmd_q == 4'b0111));

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 100,
  parameter int T_RP    = 3,
  parameter int T_RC    = 8,
  parameter int T_MRD   = 2,
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_cfg,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done
);
  localparam int unsigned STAB  = stab_cycles(CLK_MHZ, WAIT_US);
  localparam int unsigned MAXC  = max2(STAB, max2(T_RC, max2(T_RP, T_MRD)));
  localparam int          CNT_W = $clog2(MAXC + 2);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  cmd_kind_t        kind;
  logic             seq_done;
  logic [3:0]       cmd_q;

  init_timer #(.W(CNT_W), .RST_VAL(CNT_W'(STAB - 1))) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .kind(kind), .seq_done(seq_done)
  );

  init_cmd_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .kind(kind), .done_in(seq_done), .cfg(mode_cfg),
    .cmd_q(cmd_q), .addr_q(sd_addr), .ba_q(sd_ba), .cke_q(sd_cke), .done_q(init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // Window checker for the stabilization wait: counts NOP pin cycles
  logic [CNT_W:0] nop_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                                             nop_run <= '0;
    else if (cmd_q == 4'b0111 && nop_run < (CNT_W+1)'(STAB + 2)) nop_run <= nop_run + 1'b1;
  end

  // R3: precharge appears after exactly STAB NOP cycles past release
  assert_stab_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 4'b0010) |-> (nop_run == (CNT_W+1)'(STAB + 1)));

endmodule

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
  localparam int CLK_MHZ = 100;
  localparam int WAIT_US = 100;
  localparam int T_RP = 3, T_RC = 8, T_MRD = 2;
  localparam int ADDR_W = 12, BA_W = 2;
  localparam int STAB = CLK_MHZ * WAIT_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] mode_cfg = '0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [ADDR_W-1:0] sd_addr;
  logic [BA_W-1:0] sd_ba;

  int errs = 0;
  int nchk = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RC(T_RC),
                    .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BA_W(BA_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_ba(sd_ba), .init_done(init_done)
  );

  function automatic logic [ADDR_W-1:0] exp_mode(logic [ADDR_W-1:0] c);
    return c & ADDR_W'(12'h27F);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && sd_cke && !init_done
        && sd_addr == '0, "R1 reset state",
        {init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 6'b010111);
    rst_n = 1'b1;
  endtask

  task automatic abort_run(int cycles);
    do_reset();
    repeat (cycles) @(negedge clk);
  endtask

  task automatic full_run(logic [ADDR_W-1:0] cfg, string tag);
    int pre_t = 0, ref1 = 0, ref2 = 0, mrs_t = 0, done_t = 0;
    int refs = 0, extra = 0, nop_pre = 0, bad_cke = 0, bad_post = 0;
    logic pre_a10 = 0;
    logic [ADDR_W-1:0] mrs_a = '0;
    logic [BA_W-1:0] mrs_ba = '0;
    mode_cfg = cfg;
    do_reset();
    for (int idx = 1; idx < STAB + 200; idx++) begin
      logic [3:0] c;
      @(negedge clk);
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!sd_cke) bad_cke++;
      case (c)
        4'b0111: if (pre_t == 0) nop_pre++;
        4'b0010: if (pre_t == 0) begin pre_t = idx; pre_a10 = sd_addr[10]; end
                 else extra++;
        4'b0001: begin refs++; if (refs == 1) ref1 = idx; else if (refs == 2) ref2 = idx; end
        4'b0000: if (mrs_t == 0) begin mrs_t = idx; mrs_a = sd_addr; mrs_ba = sd_ba; end
                 else extra++;
        default: extra++;
      endcase
      if (init_done && done_t == 0) done_t = idx;
      if (done_t != 0 && idx >= done_t + 3) break;
    end
    chk(pre_t == STAB + 1, {tag, " R3 precharge cycle"}, pre_t, STAB + 1);
    chk(nop_pre == STAB, {tag, " R3 NOP count before precharge"}, nop_pre, STAB);
    chk(pre_a10 == 1'b1, {tag, " R4 all-banks bit"}, pre_a10, 1);
    chk(ref1 == pre_t + T_RP, {tag, " R5 first refresh"}, ref1, pre_t + T_RP);
    chk(refs == 2 && extra == 0, {tag, " R6 refresh count"}, refs * 100 + extra, 200);
    chk(ref2 == ref1 + T_RC, {tag, " R6 second refresh"}, ref2, ref1 + T_RC);
    chk(mrs_t == ref2 + T_RC, {tag, " R6 mode load cycle"}, mrs_t, ref2 + T_RC);
    chk(mrs_a == exp_mode(cfg) && mrs_ba == '0, {tag, " R7 mode word"},
        {mrs_ba, mrs_a}, exp_mode(cfg));
    chk(done_t == mrs_t + T_MRD, {tag, " R8 done cycle"}, done_t, mrs_t + T_MRD);
    chk(bad_cke == 0, {tag, " R2 clock enable"}, bad_cke, 0);
    for (int k = 0; k < 16; k++) begin
      mode_cfg = ADDR_W'($urandom);
      @(negedge clk);
      if (!init_done || sd_addr != '0 || {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111)
        bad_post++;
    end
    chk(bad_post == 0, {tag, " R8 R10 idle after done"}, bad_post, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    full_run(12'hFFF, "all-ones");
    full_run(12'h000, "all-zeros");
    abort_run(STAB + 5);
    full_run(12'h5A3, "R9 restart");
    for (int r = 0; r < 3; r++) full_run(ADDR_W'($urandom), "random");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      nchk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

endmodule